// File: doc/BRIEF.md
# Paging-Write and Guest-Path Verification Checker

This block is a second-stage permission checker that sits beside a guest page walk. Each walk step presents one access to a physical page together with that page's attributes: read, write, table-write privilege and path-verified. The checker decides whether the access is allowed. It separates software stores from processor-generated table updates, such as accessed/dirty bit writes. A page that is read-only to software can still take those hardware updates when its table-write privilege is set and the global table-write enable is on.

Across the steps of one walk, the block keeps a running flag. The flag stays true only while every guest table page fetched so far carried the table-write privilege. On the final access of the walk, a page marked path-verified is rejected if the global verification enable is on and the flag has dropped. This blocks remapped or aliased translations that pass through ordinary table pages. Each step's verdict appears one cycle later with a reason code. Attribute lookup happens outside the block.

Top module: `pwv_checker`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `out_valid`, `allow` and `violate` are low and `reason` is 00.
- R2: A step presented with `req_valid` high produces `out_valid` high exactly one cycle later, with exactly one of `allow`/`violate` set. `reason` is 00 when allowed, 01 for a write-permission violation, 10 for a read violation and 11 for a path violation. `req_valid` low gives `out_valid` low one cycle later.
- R3: A software write (`acc_kind` 11) to a page with write permission clear is rejected with reason 01 whatever its table-write privilege. With write permission set, it is allowed.
- R4: With `pw_en` high, a paging write (`acc_kind` 01) to a page with table-write privilege set is allowed even though write permission is clear. Without that privilege and without write permission, it is rejected with reason 01.
- R5: With `pw_en` low, a paging write follows ordinary write permission only: allowed with write set, reason 01 with write clear, even if the privilege is set.
- R6: A table read (`acc_kind` 00) or software read (`acc_kind` 10) to a page with read permission clear is rejected with reason 10.
- R7: With `vgp_en` high, a final step (`step_last` high) to a path-verified page is rejected with reason 11 if any table read (`acc_kind` 00, `step_last` low) since the walk's first step lacked the table-write privilege. This reason outranks a permission violation on the same step.
- R8: `walk_first` starts a fresh path. A walk whose table pages all carry the privilege, or which has no table steps at all, may reach a path-verified page.
- R9: With `vgp_en` low, the path-verified attribute has no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A walk step is presented this cycle |
| acc_kind | input | 2 | 00 table read, 01 paging write, 10 software read, 11 software write |
| walk_first | input | 1 | Step is the first of a new walk |
| step_last | input | 1 | Step is the final data access of the walk |
| attr_read | input | 1 | Page read permission |
| attr_write | input | 1 | Page write permission |
| attr_pw | input | 1 | Page table-write privilege |
| attr_vgp | input | 1 | Page requires a verified path |
| pw_en | input | 1 | Global table-write privilege enable |
| vgp_en | input | 1 | Global path verification enable |
| out_valid | output | 1 | Verdict valid (one cycle after the step) |
| allow | output | 1 | Access permitted |
| violate | output | 1 | Access rejected |
| reason | output | 2 | 00 none, 01 write, 10 read, 11 path |

## Verification
The hardest case to reach from the ports is a path violation. It needs a walk of several steps in which one ordinary table page sits in the middle of otherwise privileged ones, followed by a final access to a path-verified page. The stimulus table strings together consecutive vectors that form such walks: a clean walk, a walk with a non-privileged page in the middle, the same alias with verification disabled, and a walk abandoned by a new `walk_first`. This confirms that the running flag, not the final page alone, decides the verdict.

// File: rtl/pwv_pkg.sv
// Shared encodings for the paging-write / path verification checker.
// Assumes: access kind and reason codes are fixed-width 2-bit fields.
package pwv_pkg;
    typedef enum logic [1:0] {
        ACC_TBL_RD = 2'b00,
        ACC_PG_WR  = 2'b01,
        ACC_SW_RD  = 2'b10,
        ACC_SW_WR  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        RSN_NONE  = 2'b00,
        RSN_WRITE = 2'b01,
        RSN_READ  = 2'b10,
        RSN_PATH  = 2'b11
    } reason_e;
endpackage

// File: rtl/pwv_path_tracker.sv
// Tracks whether every table page fetched in the current walk held the
// table-write privilege. Assumes one step per cycle when step_valid is high;
// walk_first restarts the path, step_last closes it.
module pwv_path_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic step_valid,
    input  logic walk_first,
    input  logic step_last,
    input  logic is_table_rd,
    input  logic page_pw,
    output logic path_ok
);
    logic path_q;

    // Path flag as seen by this step: a new walk starts clean.
    always_comb path_ok = walk_first ? 1'b1 : path_q;

    // Fold each table fetch's privilege into the flag; reopen after a final step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            path_q <= 1'b1;
        else if (step_valid) begin
            if (step_last)
                path_q <= 1'b1;
            else if (is_table_rd)
                path_q <= path_ok & page_pw;
            else
                path_q <= path_ok;
        end
    end

    // R8: after a final step the next walk begins with a clean path.
    p_path_reopen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_last) |=> path_q);

    // R7: a table fetch without privilege leaves the path broken.
    p_path_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !step_last && is_table_rd && !page_pw) |=> !path_q);
endmodule

// File: rtl/pwv_perm_eval.sv
// Combinational verdict for one step from access kind, page attributes,
// global enables and the walk path flag. Assumes path_ok reflects all
// earlier table fetches of the current walk.
module pwv_perm_eval
    import pwv_pkg::*;
(
    input  acc_kind_e kind,
    input  logic      attr_read,
    input  logic      attr_write,
    input  logic      attr_pw,
    input  logic      attr_vgp,
    input  logic      pw_en,
    input  logic      vgp_en,
    input  logic      is_final,
    input  logic      path_ok,
    output logic      ok,
    output reason_e   why
);
    logic perm_ok;
    reason_e perm_rsn;
    logic path_fail;

    // Per-kind permission rule: hardware table updates may use the privilege.
    always_comb begin
        unique case (kind)
            ACC_TBL_RD, ACC_SW_RD: begin
                perm_ok  = attr_read;
                perm_rsn = RSN_READ;
            end
            ACC_PG_WR: begin
                perm_ok  = attr_write | (pw_en & attr_pw);
                perm_rsn = RSN_WRITE;
            end
            default: begin
                perm_ok  = attr_write;
                perm_rsn = RSN_WRITE;
            end
        endcase
    end

    // Path check applies only on the final step, with verification on.
    always_comb path_fail = vgp_en & attr_vgp & is_final & ~path_ok;

    // Combine: a path violation outranks a permission violation.
    always_comb begin
        ok  = perm_ok & ~path_fail;
        why = path_fail ? RSN_PATH : (perm_ok ? RSN_NONE : perm_rsn);
    end
endmodule

// File: rtl/pwv_checker.sv
// Top of the paging-write / path verification checker. Evaluates each walk
// step and registers the verdict one cycle later. Assumes attributes are
// valid in the same cycle as req_valid.
module pwv_checker
    import pwv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] acc_kind,
    input  logic       walk_first,
    input  logic       step_last,
    input  logic       attr_read,
    input  logic       attr_write,
    input  logic       attr_pw,
    input  logic       attr_vgp,
    input  logic       pw_en,
    input  logic       vgp_en,
    output logic       out_valid,
    output logic       allow,
    output logic       violate,
    output logic [1:0] reason
);
    acc_kind_e kind;
    logic      path_ok;
    logic      eval_ok;
    reason_e   eval_why;

    // Cast the raw access field onto the shared enum.
    always_comb kind = acc_kind_e'(acc_kind);

    pwv_path_tracker u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (req_valid),
        .walk_first (walk_first),
        .step_last  (step_last),
        .is_table_rd(kind == ACC_TBL_RD),
        .page_pw    (attr_pw),
        .path_ok    (path_ok)
    );

    pwv_perm_eval u_eval (
        .kind      (kind),
        .attr_read (attr_read),
        .attr_write(attr_write),
        .attr_pw   (attr_pw),
        .attr_vgp  (attr_vgp),
        .pw_en     (pw_en),
        .vgp_en    (vgp_en),
        .is_final  (step_last),
        .path_ok   (path_ok),
        .ok        (eval_ok),
        .why       (eval_why)
    );

    // Register the verdict; idle cycles drive a clean zero result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            allow     <= 1'b0;
            violate   <= 1'b0;
            reason    <= RSN_NONE;
        end else begin
            out_valid <= req_valid;
            allow     <= req_valid & eval_ok;
            violate   <= req_valid & ~eval_ok;
            reason    <= req_valid ? eval_why : RSN_NONE;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !allow && !violate && reason == 2'b00));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (allow ^ violate) && ((reason == 2'b00) == allow));

    p_sw_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'b11 && !attr_write) |=> violate);

    p_pg_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'b01 && pw_en && attr_pw
         && !(step_last && vgp_en && attr_vgp)) |=> allow);

    p_pg_write_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'b01 && !pw_en && !attr_write) |=> violate);

    p_vgp_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !vgp_en) |=> reason != 2'b11);
endmodule

// File: tb/pwv_checker_test.sv
module pwv_checker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] acc_kind = 2'b00;
    logic       walk_first = 1'b0, step_last = 1'b0;
    logic       attr_read = 1'b0, attr_write = 1'b0, attr_pw = 1'b0, attr_vgp = 1'b0;
    logic       pw_en = 1'b0, vgp_en = 1'b0;
    logic       out_valid, allow, violate;
    logic [1:0] reason;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    pwv_checker uut (.*);

    // {kind[1:0], first, last, r, w, pw, vgp, pwen, vgpen, exp_allow, exp_rsn[1:0], req[3:0]}
    localparam int NV = 23;
    localparam logic [16:0] VEC [NV] = '{
        {2'b11,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0, 1'b0,2'b01, 4'd3}, // R3 sw write, ro, pw
        {2'b01,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0, 1'b1,2'b00, 4'd4}, // R4 paging write ro+pw
        {2'b01,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0, 1'b0,2'b01, 4'd5}, // R5 enable off
        {2'b01,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b1,2'b00, 4'd5}, // R5 writable
        {2'b01,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0, 1'b0,2'b01, 4'd4}, // R4 no pw
        {2'b10,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1, 1'b0,2'b10, 4'd6}, // R6 sw read
        {2'b00,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1, 1'b0,2'b10, 4'd6}, // R6 table read
        {2'b00,1'b1,1'b0, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 1'b1,2'b00, 4'd8}, // R8 clean walk
        {2'b00,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 1'b1,2'b00, 4'd8},
        {2'b10,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1, 1'b1,2'b00, 4'd8},
        {2'b00,1'b1,1'b0, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 1'b1,2'b00, 4'd7}, // R7 alias walk
        {2'b00,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 1'b1,2'b00, 4'd7},
        {2'b00,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 1'b1,2'b00, 4'd7},
        {2'b10,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1, 1'b0,2'b11, 4'd7},
        {2'b00,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0, 1'b1,2'b00, 4'd9}, // R9 alias, vgp off
        {2'b10,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 1'b1,2'b00, 4'd9},
        {2'b00,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 1'b1,2'b00, 4'd8}, // R8 abandoned walk
        {2'b00,1'b1,1'b0, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 1'b1,2'b00, 4'd8},
        {2'b10,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1, 1'b1,2'b00, 4'd8},
        {2'b00,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 1'b1,2'b00, 4'd7}, // R7 priority
        {2'b11,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1, 1'b0,2'b11, 4'd7},
        {2'b10,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1, 1'b1,2'b00, 4'd8}, // R8 no tables
        {2'b11,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1, 1'b1,2'b00, 4'd3}  // R3 writable
    };

    task automatic check(input string tag, input logic v, input logic a,
                         input logic x, input logic [1:0] r);
        n_chk++;
        if (out_valid !== v || allow !== a || violate !== x || reason !== r) begin
            n_bad++;
            $display("FAIL %s: got v=%b a=%b x=%b r=%b, expected v=%b a=%b x=%b r=%b",
                     tag, out_valid, allow, violate, reason, v, a, x, r);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got running, expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 1'b0, 1'b0, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, 1'b0, 1'b0, 2'b00);

        for (int i = 0; i < NV; i++) begin
            logic [16:0] e;
            e = VEC[i];
            req_valid = 1'b1;
            {acc_kind, walk_first, step_last, attr_read, attr_write, attr_pw,
             attr_vgp, pw_en, vgp_en} = e[16:7];
            @(negedge clk);
            check($sformatf("R%0d vec %0d", e[3:0], i), 1'b1, e[6], ~e[6], e[5:4]);
        end

        // R2: idle step gives no verdict
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 idle", 1'b0, 1'b0, 1'b0, 2'b00);

        // R7: broken path persists across an idle cycle
        req_valid = 1'b1; acc_kind = 2'b00; walk_first = 1'b1; step_last = 1'b0;
        attr_read = 1'b1; attr_pw = 1'b0; attr_vgp = 1'b0; vgp_en = 1'b1;
        @(negedge clk);
        check("R7 setup", 1'b1, 1'b1, 1'b0, 2'b00);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; acc_kind = 2'b10; walk_first = 1'b0; step_last = 1'b1;
        attr_vgp = 1'b1;
        @(negedge clk);
        check("R7 after gap", 1'b1, 1'b0, 1'b1, 2'b11);

        // R1: reset while a verdict is pending clears outputs
        acc_kind = 2'b11; attr_write = 1'b0; attr_vgp = 1'b0; walk_first = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", 1'b0, 1'b0, 1'b0, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 after reset", 1'b1, 1'b0, 1'b1, 2'b01);
        req_valid = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule